// File: doc/BRIEF.md
# Paged Network Controller Register File

This block is the byte-wide host register file of an Ethernet controller. The host reaches it through a 4-bit offset, a one-cycle write strobe and a combinational read bus. Offset 0 is always the command register. Its two top bits pick one of four register pages, so every other offset resolves to an effective index of page times 16 plus offset. Reads and writes at the same index can reach different registers.

The block stores the receive ring pages (start, stop, boundary, current), the transmit page and byte count, and the remote start address and byte count. It also stores the receive and data configuration bytes, a six-byte station address and an eight-byte multicast hash table. All of these are presented on parallel outputs for the frame datapath. An interrupt status byte and an interrupt mask byte drive a single interrupt line. The command register starts transmissions through a one-cycle pulse, and a transmit-done input reports their end.

Top module: `nic_regfile`

## Requirements
- R1: After reset the command register reads 0x01 and the interrupt status reads 0x80. The transmit status, every configuration output and the interrupt mask are 0, and the interrupt line and the transmit pulse are low.
- R2: Offset 0 reads and writes the command register on every page. Any other offset resolves to effective index {command[7:6], offset}.
- R3: Page 0 writes store the following: index 0x01 ring start, 0x02 ring stop, 0x03 boundary, 0x04 transmit page, 0x05/0x06 transmit count low/high, 0x08/0x09 remote address low/high, 0x0A/0x0B remote count low/high, 0x0C receive config, 0x0E data config and 0x0F interrupt mask. A write to index 0x0D stores nothing.
- R4: Page 0 reads return the following: boundary at 0x03, transmit status at 0x04, interrupt status at 0x07, remote address low at 0x08 and remote address high at 0x09. All other page 0 offsets read 0.
- R5: On page 1, indices 0x11..0x16 read and write station address bytes 0..5 (byte k on stationAddr[8k+7:8k]). Index 0x17 reads and writes the current page. Indices 0x18..0x1F read and write multicast bytes 0..7 (byte k on mcastTable[8k+7:8k]).
- R6: On page 2, index 0x21 reads the ring start and 0x22 reads the ring stop. Page 2 and page 3 writes change nothing, and every read index not listed in R4–R6 returns 0.
- R7: A command write with bit 0 (stop) clear clears status bit 7 (reset complete). A command write with bit 0 set leaves bit 7 unchanged.
- R8: A command write with bit 0 clear and bit 3 (remote read) or bit 4 (remote write) set sets status bit 6 at once if the remote count is 0. It leaves bit 6 alone if the remote count is nonzero.
- R9: A write to index 0x07 clears each status bit 6:0 that is 1 in the written byte. Bit 7 is never cleared this way and never set except by reset.
- R10: The interrupt line is high exactly when (status AND mask AND 0x7F) is nonzero, so status bit 7 alone never raises it.
- R11: A command write with bit 2 (transmit) set and bit 0 clear drives txStart high for exactly the one cycle after the write. With bit 0 set, no pulse is produced.
- R12: A txDone cycle makes the following hold from the next cycle: command bit 2 reads 0, the transmit status reads 0x01 and status bit 1 is set. If a command write falls in the same cycle, the written command value is kept whole.
- R13: When txDone coincides with a status write that clears bit 1, bit 1 ends set (set wins over clear).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register offset |
| wrEn | input | 1 | Single-cycle write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for addr and current page |
| txDone | input | 1 | Transmit finished event, one cycle |
| txStart | output | 1 | One-cycle transmit request |
| irq | output | 1 | Interrupt line |
| ringStart | output | 8 | Receive ring start page |
| ringStop | output | 8 | Receive ring stop page |
| boundaryPage | output | 8 | Ring boundary page |
| currentPage | output | 8 | Ring current page |
| txPage | output | 8 | Transmit start page |
| txCount | output | 16 | Transmit byte count |
| remoteAddr | output | 16 | Remote start address |
| remoteCount | output | 16 | Remote byte count |
| rxConfig | output | 8 | Receive configuration byte |
| dataConfig | output | 8 | Data configuration byte |
| intrMask | output | 8 | Interrupt mask |
| stationAddr | output | 48 | Station address, byte 0 lowest |
| mcastTable | output | 64 | Multicast hash table, byte 0 lowest |

## Verification
The two functions that can meet in one cycle are the transmit-done event and a host write. That host write is either a status-clear write that targets bit 1 or a command write. The bench raises txDone in the very cycle its write strobe is high. It then reads back the interrupt status and the command register, expecting bit 1 to survive the clear and the freshly written command to be kept whole. Random register traffic across all four pages runs beside the directed cases and is compared against a shadow model, so that page aliasing shows up as a read-back or output mismatch.

// File: rtl/nic_reg_pkg.sv
package nic_reg_pkg;
  localparam int DATA_W        = 8;
  localparam int ADDR_W        = 4;
  localparam int PAGE_W        = 2;
  localparam int IDX_W         = ADDR_W + PAGE_W;
  localparam int STATION_BYTES = 6;
  localparam int MCAST_BYTES   = 8;
  localparam int WIDE_W        = 2 * DATA_W;

  // command bits
  localparam int CMD_STOP   = 0;
  localparam int CMD_TX     = 2;
  localparam int CMD_RREAD  = 3;
  localparam int CMD_RWRITE = 4;

  // status bits
  localparam int ISR_TX  = 1;
  localparam int ISR_RDC = 6;
  localparam int ISR_RST = 7;

  localparam logic [DATA_W-1:0] CMD_RESET_VAL = 8'h01;
  localparam logic [DATA_W-1:0] ISR_RESET_VAL = 8'h80;
  localparam logic [DATA_W-1:0] TSR_DONE_VAL  = 8'h01;
  localparam logic [DATA_W-1:0] IRQ_BITS      = 8'h7F;

  // page 0 write indices
  localparam logic [IDX_W-1:0] W_START   = 6'h01;
  localparam logic [IDX_W-1:0] W_STOP    = 6'h02;
  localparam logic [IDX_W-1:0] W_BOUND   = 6'h03;
  localparam logic [IDX_W-1:0] W_TXPAGE  = 6'h04;
  localparam logic [IDX_W-1:0] W_TXCNTL  = 6'h05;
  localparam logic [IDX_W-1:0] W_TXCNTH  = 6'h06;
  localparam logic [IDX_W-1:0] W_STATUS  = 6'h07;
  localparam logic [IDX_W-1:0] W_RADDRL  = 6'h08;
  localparam logic [IDX_W-1:0] W_RADDRH  = 6'h09;
  localparam logic [IDX_W-1:0] W_RCNTL   = 6'h0A;
  localparam logic [IDX_W-1:0] W_RCNTH   = 6'h0B;
  localparam logic [IDX_W-1:0] W_RXCFG   = 6'h0C;
  localparam logic [IDX_W-1:0] W_DATACFG = 6'h0E;
  localparam logic [IDX_W-1:0] W_MASK    = 6'h0F;

  // page 0 read indices
  localparam logic [IDX_W-1:0] R_BOUND   = 6'h03;
  localparam logic [IDX_W-1:0] R_TXSTAT  = 6'h04;
  localparam logic [IDX_W-1:0] R_STATUS  = 6'h07;
  localparam logic [IDX_W-1:0] R_RADDRL  = 6'h08;
  localparam logic [IDX_W-1:0] R_RADDRH  = 6'h09;

  // page 1 (read and write)
  localparam logic [IDX_W-1:0] P1_STATION0 = 6'h11;
  localparam logic [IDX_W-1:0] P1_CURPAGE  = 6'h17;
  localparam logic [IDX_W-1:0] P1_MCAST0   = 6'h18;

  // page 2 read indices
  localparam logic [IDX_W-1:0] R_START2 = 6'h21;
  localparam logic [IDX_W-1:0] R_STOP2  = 6'h22;

  // strobes from control to datapath
  typedef struct packed {
    logic              wr;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] val;
    logic [DATA_W-1:0] isrSet;
    logic [DATA_W-1:0] isrClr;
    logic              txDoneEv;
  } regStrobeT;
endpackage

// File: rtl/nic_reg_ctrl.sv
module nic_reg_ctrl
  import nic_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              txDone,
  input  logic              rcntZero,
  output logic [DATA_W-1:0] cmdQ,
  output logic [IDX_W-1:0]  effIdx,
  output regStrobeT         strobe,
  output logic              txStart
);
  logic cmdSel;
  logic cmdWr;
  logic runWr;
  logic remoteReq;

  assign cmdSel    = (addr == '0);
  assign cmdWr     = wrEn && cmdSel;
  assign runWr     = cmdWr && !wrData[CMD_STOP];
  assign remoteReq = wrData[CMD_RREAD] || wrData[CMD_RWRITE];
  assign effIdx    = {cmdQ[DATA_W-1 -: PAGE_W], addr};

  always_comb begin
    strobe          = '0;
    strobe.wr       = wrEn && !cmdSel;
    strobe.idx      = effIdx;
    strobe.val      = wrData;
    strobe.txDoneEv = txDone;
    if (runWr && remoteReq && rcntZero) strobe.isrSet[ISR_RDC] = 1'b1;
    if (txDone)                         strobe.isrSet[ISR_TX]  = 1'b1;
    if (runWr)                          strobe.isrClr[ISR_RST] = 1'b1;
    if (wrEn && !cmdSel && effIdx == W_STATUS)
      strobe.isrClr = strobe.isrClr | (wrData & IRQ_BITS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ    <= CMD_RESET_VAL;
      txStart <= 1'b0;
    end else begin
      if (cmdWr)       cmdQ         <= wrData;
      else if (txDone) cmdQ[CMD_TX] <= 1'b0;
      txStart <= runWr && wrData[CMD_TX];
    end
  end
endmodule

// File: rtl/nic_reg_data.sv
module nic_reg_data
  import nic_reg_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  regStrobeT                    strobe,
  input  logic [IDX_W-1:0]             rdIdx,
  output logic [DATA_W-1:0]            rdData,
  output logic                         irq,
  output logic                         rcntZero,
  output logic [DATA_W-1:0]            isrQ,
  output logic [DATA_W-1:0]            ringStart,
  output logic [DATA_W-1:0]            ringStop,
  output logic [DATA_W-1:0]            boundaryPage,
  output logic [DATA_W-1:0]            currentPage,
  output logic [DATA_W-1:0]            txPage,
  output logic [WIDE_W-1:0]            txCount,
  output logic [WIDE_W-1:0]            remoteAddr,
  output logic [WIDE_W-1:0]            remoteCount,
  output logic [DATA_W-1:0]            rxConfig,
  output logic [DATA_W-1:0]            dataConfig,
  output logic [DATA_W-1:0]            intrMask,
  output logic [STATION_BYTES*DATA_W-1:0] stationAddr,
  output logic [MCAST_BYTES*DATA_W-1:0]   mcastTable
);
  logic [DATA_W-1:0] tsrQ;
  logic [DATA_W-1:0] stationQ [STATION_BYTES];
  logic [DATA_W-1:0] mcastQ   [MCAST_BYTES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ringStart    <= '0;
      ringStop     <= '0;
      boundaryPage <= '0;
      currentPage  <= '0;
      txPage       <= '0;
      txCount      <= '0;
      remoteAddr   <= '0;
      remoteCount  <= '0;
      rxConfig     <= '0;
      dataConfig   <= '0;
      intrMask     <= '0;
    end else if (strobe.wr) begin
      case (strobe.idx)
        W_START:    ringStart                 <= strobe.val;
        W_STOP:     ringStop                  <= strobe.val;
        W_BOUND:    boundaryPage              <= strobe.val;
        W_TXPAGE:   txPage                    <= strobe.val;
        W_TXCNTL:   txCount[DATA_W-1:0]       <= strobe.val;
        W_TXCNTH:   txCount[WIDE_W-1:DATA_W]  <= strobe.val;
        W_RADDRL:   remoteAddr[DATA_W-1:0]    <= strobe.val;
        W_RADDRH:   remoteAddr[WIDE_W-1:DATA_W] <= strobe.val;
        W_RCNTL:    remoteCount[DATA_W-1:0]   <= strobe.val;
        W_RCNTH:    remoteCount[WIDE_W-1:DATA_W] <= strobe.val;
        W_RXCFG:    rxConfig                  <= strobe.val;
        W_DATACFG:  dataConfig                <= strobe.val;
        W_MASK:     intrMask                  <= strobe.val;
        P1_CURPAGE: currentPage               <= strobe.val;
        default: ;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < STATION_BYTES; g++) begin : gStation
      localparam logic [IDX_W-1:0] MY_IDX = P1_STATION0 + IDX_W'(g);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stationQ[g] <= '0;
        else if (strobe.wr && strobe.idx == MY_IDX) stationQ[g] <= strobe.val;
      end
      assign stationAddr[g*DATA_W +: DATA_W] = stationQ[g];
    end
    for (genvar g = 0; g < MCAST_BYTES; g++) begin : gMcast
      localparam logic [IDX_W-1:0] MY_IDX = P1_MCAST0 + IDX_W'(g);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) mcastQ[g] <= '0;
        else if (strobe.wr && strobe.idx == MY_IDX) mcastQ[g] <= strobe.val;
      end
      assign mcastTable[g*DATA_W +: DATA_W] = mcastQ[g];
    end
  endgenerate

  // status: set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isrQ <= ISR_RESET_VAL;
      tsrQ <= '0;
    end else begin
      isrQ <= (isrQ & ~strobe.isrClr) | strobe.isrSet;
      if (strobe.txDoneEv) tsrQ <= TSR_DONE_VAL;
    end
  end

  always_comb begin
    rdData = '0;
    case (rdIdx)
      R_BOUND:    rdData = boundaryPage;
      R_TXSTAT:   rdData = tsrQ;
      R_STATUS:   rdData = isrQ;
      R_RADDRL:   rdData = remoteAddr[DATA_W-1:0];
      R_RADDRH:   rdData = remoteAddr[WIDE_W-1:DATA_W];
      P1_CURPAGE: rdData = currentPage;
      R_START2:   rdData = ringStart;
      R_STOP2:    rdData = ringStop;
      default: ;
    endcase
    for (int k = 0; k < STATION_BYTES; k++)
      if (rdIdx == P1_STATION0 + IDX_W'(k)) rdData = stationQ[k];
    for (int k = 0; k < MCAST_BYTES; k++)
      if (rdIdx == P1_MCAST0 + IDX_W'(k)) rdData = mcastQ[k];
  end

  assign irq      = |(isrQ & intrMask & IRQ_BITS);
  assign rcntZero = (remoteCount == '0);
endmodule

// File: rtl/nic_regfile.sv
module nic_regfile
  import nic_reg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  addr,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  input  logic        txDone,
  output logic        txStart,
  output logic        irq,
  output logic [7:0]  ringStart,
  output logic [7:0]  ringStop,
  output logic [7:0]  boundaryPage,
  output logic [7:0]  currentPage,
  output logic [7:0]  txPage,
  output logic [15:0] txCount,
  output logic [15:0] remoteAddr,
  output logic [15:0] remoteCount,
  output logic [7:0]  rxConfig,
  output logic [7:0]  dataConfig,
  output logic [7:0]  intrMask,
  output logic [47:0] stationAddr,
  output logic [63:0] mcastTable
);
  logic [DATA_W-1:0] cmdQ;
  logic [DATA_W-1:0] isrQ;
  logic [DATA_W-1:0] dpRdData;
  logic [IDX_W-1:0]  effIdx;
  logic              rcntZero;
  regStrobeT         strobe;

  nic_reg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .txDone(txDone), .rcntZero(rcntZero), .cmdQ(cmdQ), .effIdx(effIdx),
    .strobe(strobe), .txStart(txStart)
  );

  nic_reg_data u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdIdx(effIdx),
    .rdData(dpRdData), .irq(irq), .rcntZero(rcntZero), .isrQ(isrQ),
    .ringStart(ringStart), .ringStop(ringStop), .boundaryPage(boundaryPage),
    .currentPage(currentPage), .txPage(txPage), .txCount(txCount),
    .remoteAddr(remoteAddr), .remoteCount(remoteCount), .rxConfig(rxConfig),
    .dataConfig(dataConfig), .intrMask(intrMask), .stationAddr(stationAddr),
    .mcastTable(mcastTable)
  );

  assign rdData = (addr == '0) ? cmdQ : dpRdData;
endmodule

// File: rtl/nic_regfile_checks.sv
module nic_regfile_checks (
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  addr,
  input logic        wrEn,
  input logic [7:0]  wrData,
  input logic        txDone,
  input logic        txStart,
  input logic        irq,
  input logic [7:0]  cmdQ,
  input logic [7:0]  isrQ,
  input logic [15:0] remoteCount
);
  assert_rst_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 4'h0 && !wrData[0]) |=> !isrQ[7]);

  assert_rst_no_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(isrQ[7]));

  assert_rdc_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 4'h0 && !wrData[0] && (wrData[3] || wrData[4]) && remoteCount == 16'h0)
    |=> isrQ[6]);

  assert_status_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 4'h7 && cmdQ[7:6] == 2'b00 && !txDone)
    |=> ((isrQ[6:0] & $past(wrData[6:0])) == 7'h0));

  assert_tx_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> $past(wrEn && addr == 4'h0 && wrData[2] && !wrData[0]));

  assert_tx_done_R12: assert property (@(posedge clk) disable iff (!rstN)
    (txDone && !(wrEn && addr == 4'h0)) |=> (isrQ[1] && !cmdQ[2]));

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (isrQ == 8'h80) |-> !irq);
endmodule

bind nic_regfile nic_regfile_checks u_checks (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
  .txDone(txDone), .txStart(txStart), .irq(irq), .cmdQ(cmdQ), .isrQ(isrQ),
  .remoteCount(remoteCount)
);

// File: tb/nic_regfile_bench.sv
module nic_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic        txDone = 1'b0;
  logic [7:0]  rdData;
  logic        txStart, irq;
  logic [7:0]  ringStart, ringStop, boundaryPage, currentPage, txPage;
  logic [15:0] txCount, remoteAddr, remoteCount;
  logic [7:0]  rxConfig, dataConfig, intrMask;
  logic [47:0] stationAddr;
  logic [63:0] mcastTable;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] expReg [64];
  logic [7:0] expCmd, expIsr, expTsr;

  always #(CLK_PERIOD/2) clk = ~clk;

  nic_regfile u_nic_regfile (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .txDone(txDone), .txStart(txStart), .irq(irq),
    .ringStart(ringStart), .ringStop(ringStop), .boundaryPage(boundaryPage),
    .currentPage(currentPage), .txPage(txPage), .txCount(txCount),
    .remoteAddr(remoteAddr), .remoteCount(remoteCount), .rxConfig(rxConfig),
    .dataConfig(dataConfig), .intrMask(intrMask), .stationAddr(stationAddr),
    .mcastTable(mcastTable)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: optional write and optional txDone, inputs changed at negedge
  task automatic cyc(input bit doWr, input logic [3:0] a, input logic [7:0] d, input bit doTx);
    @(negedge clk);
    wrEn = doWr; addr = a; wrData = d; txDone = doTx;
    @(negedge clk);
    wrEn = 1'b0; txDone = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdData;
  endtask

  function automatic bit storable(input int idx);
    if (idx >= 8'h11 && idx <= 8'h1F) return 1;
    if (idx >= 1 && idx <= 15 && idx != 7 && idx != 13) return 1;
    return 0;
  endfunction

  function automatic logic [7:0] expRead(input int idx);
    case (idx)
      8'h03, 8'h08, 8'h09: return expReg[idx];
      8'h04: return expTsr;
      8'h07: return expIsr;
      8'h21: return expReg[1];
      8'h22: return expReg[2];
      default: return (idx >= 8'h11 && idx <= 8'h1F) ? expReg[idx] : 8'h00;
    endcase
  endfunction

  task automatic chkPorts(input string tag);
    chk({tag, " R3 ring"}, {ringStart, ringStop, boundaryPage, txPage},
        {expReg[1], expReg[2], expReg[3], expReg[4]});
    chk({tag, " R3 counts"}, {txCount, remoteAddr, remoteCount},
        {expReg[6], expReg[5], expReg[9], expReg[8], expReg[11], expReg[10]});
    chk({tag, " R3 cfg"}, {rxConfig, dataConfig, intrMask},
        {expReg[12], expReg[14], expReg[15]});
    for (int k = 0; k < 6; k++)
      chk({tag, " R5 station"}, stationAddr[8*k +: 8], expReg[8'h11 + k]);
    for (int k = 0; k < 8; k++)
      chk({tag, " R5 mcast"}, mcastTable[8*k +: 8], expReg[8'h18 + k]);
    chk({tag, " R5 curpage"}, currentPage, expReg[8'h17]);
  endtask

  task automatic resetAll();
    rstN = 1'b0;
    for (int i = 0; i < 64; i++) expReg[i] = 8'h00;
    expCmd = 8'h01; expIsr = 8'h80; expTsr = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    void'($urandom(32'h5EED_0042));
    resetAll();

    // R1 reset state
    rd(4'h0, v); chk("R1 cmd", v, 8'h01);
    rd(4'h7, v); chk("R1 status", v, 8'h80);
    rd(4'h4, v); chk("R1 tx status", v, 8'h00);
    chk("R1 irq/txStart", {irq, txStart}, 2'b00);
    chkPorts("R1");

    // random paged traffic (R2..R6)
    for (int it = 0; it < 300; it++) begin
      logic [1:0] pg;
      logic [3:0] off;
      logic [7:0] d;
      int idx;
      pg  = 2'($urandom_range(0, 3));
      off = 4'($urandom_range(1, 15));
      if (pg == 2'b00 && off == 4'h7) off = 4'h6;
      d   = 8'($urandom);
      wr(4'h0, {pg, 6'b000001});
      expCmd = {pg, 6'b000001};
      rd(4'h0, v); chk("R2 cmd any page", v, expCmd);
      idx = {pg, off};
      wr(off, d);
      if (storable(idx)) expReg[idx] = d;
      rd(off, v); chk("R2 R4 R5 R6 readback", v, expRead(idx));
      chk("R9 status untouched", {1'b0, irq}, 2'b00);
      if (it % 25 == 0) chkPorts("R6 random");
    end
    chkPorts("R3 final");
    rd(4'h0, v);
    wr(4'h0, 8'h01); expCmd = 8'h01;
    rd(4'h7, v); chk("R7 stop keeps bit7", v, 8'h80);

    // R10 bit7 alone cannot interrupt
    wr(4'hF, 8'hFF); expReg[15] = 8'hFF;
    chk("R10 bit7 masked", irq, 1'b0);

    // R7 start clears bit7
    wr(4'hA, 8'h00); wr(4'hB, 8'h00);
    wr(4'h0, 8'h22);
    rd(4'h7, v); chk("R7 start clears bit7", v, 8'h00);

    // R8 zero count remote read
    wr(4'h0, 8'h0A);
    rd(4'h7, v); chk("R8 zero count sets bit6", v, 8'h40);
    chk("R10 irq on bit6", irq, 1'b1);
    wr(4'h7, 8'h40);
    rd(4'h7, v); chk("R9 clear bit6", v, 8'h00);
    chk("R10 irq low", irq, 1'b0);

    // R8 nonzero count
    wr(4'hA, 8'h05);
    wr(4'h0, 8'h12);
    rd(4'h7, v); chk("R8 nonzero count", v, 8'h00);
    // R8 stop set blocks
    wr(4'hA, 8'h00);
    wr(4'h0, 8'h09);
    rd(4'h7, v); chk("R8 stop blocks", v, 8'h00);

    // R11 transmit pulse
    wr(4'h0, 8'h26);
    chk("R11 pulse high", txStart, 1'b1);
    @(negedge clk);
    chk("R11 pulse one cycle", txStart, 1'b0);
    rd(4'h0, v); chk("R2 cmd holds tx", v, 8'h26);

    // R12 transmit done
    cyc(1'b0, 4'h0, 8'h00, 1'b1);
    rd(4'h0, v); chk("R12 tx bit cleared", v, 8'h22);
    rd(4'h4, v); chk("R12 tx status", v, 8'h01);
    rd(4'h7, v); chk("R12 status bit1", v, 8'h02);
    chk("R10 irq on bit1", irq, 1'b1);

    // R11 no pulse when stopped
    wr(4'h0, 8'h05);
    chk("R11 stopped no pulse", txStart, 1'b0);
    wr(4'h0, 8'h22);

    // R13 set beats clear
    wr(4'h7, 8'hFF);
    rd(4'h7, v); chk("R9 clear all", v, 8'h00);
    cyc(1'b1, 4'h7, 8'h02, 1'b1);
    rd(4'h7, v); chk("R13 set wins", v, 8'h02);

    // R12 host command write wins same cycle
    cyc(1'b1, 4'h0, 8'h26, 1'b1);
    chk("R11 pulse with done", txStart, 1'b1);
    rd(4'h0, v); chk("R12 host write kept", v, 8'h26);
    cyc(1'b0, 4'h0, 8'h00, 1'b1);

    // R9 bit7 not clearable, R1 after second reset
    resetAll();
    rd(4'h7, v); chk("R1 status again", v, 8'h80);
    wr(4'h7, 8'hFF);
    rd(4'h7, v); chk("R9 bit7 kept", v, 8'h80);
    chkPorts("R1 again");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule